// File: doc/BRIEF.md
# Laser Transmit Fault and Disable Controller

This block is the control state machine for the transmit laser of a pluggable optical module. It watches three inputs: a supply-good indication, the host's transmit-disable pin and a fault-detect signal from the laser driver's safety circuit. From these it drives a laser-enable output and a latched fault flag. It sequences power-up initialization, turns the laser off and on as the host disable pin moves, and latches a laser fault. It also clears that fault only through a deliberate host action.

A detected fault turns the laser off and raises the flag, which then holds even after the detector goes quiet. The host clears it either by pulsing the disable pin for at least a minimum width or by removing and restoring power. After a qualifying pulse the laser is re-enabled for a retry period. A fault that has gone away leaves the flag clear, and a fault that is still present raises it again at once. A disable pulse that is too short does not clear the fault, but in normal operation it still darkens the laser while it is high. All timing is set by parameters in microseconds, converted to clock cycles from the clock frequency. A two-bit status word mirrors the fault and disable conditions for a management reader.

Top module: `ltx_fault_ctrl`

## Requirements
- R1: While `rst` is high and for as long as `pwr_ok_i` stays low, `laser_on_o` and `fault_o` are 0.
- R2: When `pwr_ok_i` rises with `host_dis_i` low, `laser_on_o` stays 0 and rises exactly 3 + INIT cycles after the input edge, where INIT = ceil(CLK_KHZ*INIT_US/1000).
- R3: While running, raising `host_dis_i` drives `laser_on_o` low 3 cycles after the input edge.
- R4: Lowering `host_dis_i` from the disabled condition drives `laser_on_o` high again 3 cycles after the input edge.
- R5: A high `drv_fault_i` while running makes `fault_o` 1 and `laser_on_o` 0 three cycles later, and `fault_o` stays 1 after `drv_fault_i` returns low.
- R6: While the fault is latched, a `host_dis_i` high pulse shorter than DMIN = ceil(CLK_KHZ*DIS_MIN_US/1000) cycles leaves `fault_o` at 1.
- R7: While the fault is latched, a `host_dis_i` high pulse of at least DMIN cycles clears `fault_o` and sets `laser_on_o` 3 cycles after the falling edge. If `drv_fault_i` is then still high, `fault_o` returns to 1 and `laser_on_o` to 0 one cycle after that. Otherwise the laser stays on.
- R8: `stat_o[1]` equals `fault_o` delayed by one cycle, and `stat_o[0]` equals `host_dis_i` delayed by 3 cycles.
- R9: Three cycles after `pwr_ok_i` falls, `laser_on_o` and `fault_o` are both 0, which clears a latched fault. Restoring power re-runs the R2 sequence.
- R10: While running, a `host_dis_i` pulse shorter than DMIN still turns `laser_on_o` off 3 cycles after it rises, and on again 3 cycles after it falls.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_ok_i | input | 1 | Supply above its operating threshold |
| host_dis_i | input | 1 | Host transmit disable, high or floating-high turns the laser off |
| drv_fault_i | input | 1 | Fault detect from the laser driver safety circuit |
| laser_on_o | output | 1 | Laser enable to the driver |
| fault_o | output | 1 | Latched transmit fault flag |
| stat_o | output | 2 | Status mirror: bit 1 fault, bit 0 disable level |

## Verification
Each input passes through a two-stage synchronizer before the state register. Every laser-enable and fault-flag result is therefore due 3 cycles after the input edge, and a status bit one cycle after the condition it mirrors. The end of initialization or of a retry falls INIT cycles after the state is entered. For each stimulus, the driver queues the expected value for the cycle just before the change and for the exact cycle of the change. The monitor compares them on the falling clock edge of that cycle. Pulse-width cases use DMIN-1 and DMIN cycles, so the acceptance boundary is checked from both sides.

// File: rtl/ltx_pkg.sv
package ltx_pkg;

    typedef enum logic [2:0] {
        ST_OFF   = 3'd0,
        ST_BOOT  = 3'd1,
        ST_RUN   = 3'd2,
        ST_HOLD  = 3'd3,
        ST_TRIP  = 3'd4,
        ST_RETRY = 3'd5
    } ltx_state_e;

    typedef struct packed {
        logic pwr;
        logic dis;
        logic flt;
    } ltx_in_t;

    // microseconds to clock cycles, rounded up, at least one cycle
    function automatic int unsigned us_to_cycles(input int unsigned khz,
                                                 input int unsigned us);
        longint unsigned prod;
        longint unsigned cyc;
        prod = longint'(khz) * longint'(us);
        cyc  = (prod + 64'd999) / 64'd1000;
        if (cyc == 64'd0) cyc = 64'd1;
        return int'(cyc);
    endfunction

    function automatic logic laser_allowed(input ltx_state_e s);
        return (s == ST_RUN) || (s == ST_RETRY);
    endfunction

    function automatic logic timed_state(input ltx_state_e s);
        return (s == ST_BOOT) || (s == ST_RETRY);
    endfunction

endpackage

// File: rtl/ltx_sync.sv
module ltx_sync #(
    parameter int          W       = 3,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] pipe [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/ltx_pulse_qual.sv
module ltx_pulse_qual #(
    parameter int MIN_CYC = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    output logic accept
);
    localparam int CW = $clog2(MIN_CYC + 1);
    localparam logic [CW-1:0] MINV = CW'(MIN_CYC);

    logic [CW-1:0] width_q;
    logic          lvl_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            width_q <= '0;
            lvl_d   <= 1'b1;
        end else begin
            lvl_d <= lvl;
            if (!lvl)
                width_q <= '0;
            else if (width_q != MINV)
                width_q <= width_q + 1'b1;
        end
    end

    // falling edge of a pulse that lasted at least MIN_CYC cycles
    assign accept = lvl_d && !lvl && (width_q == MINV);
endmodule

// File: rtl/ltx_timer.sv
module ltx_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          expired
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/ltx_fsm.sv
module ltx_fsm
    import ltx_pkg::*;
#(
    parameter int unsigned INIT_CYC = 40,
    parameter int          TW       = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  ltx_in_t       in_s,
    input  logic          tog,
    input  logic          tmr_done,
    output logic          tmr_load,
    output logic [TW-1:0] tmr_val,
    output logic          laser_on,
    output logic          fault,
    output logic [1:0]    stat
);
    localparam logic [TW-1:0] INIT_LOAD = TW'(INIT_CYC - 1);

    ltx_state_e state_q, state_n;
    logic [1:0] stat_q;

    always_comb begin
        state_n = state_q;
        if (!in_s.pwr) begin
            state_n = ST_OFF;
        end else begin
            unique case (state_q)
                ST_OFF:   state_n = ST_BOOT;
                ST_BOOT:  if (tmr_done) state_n = in_s.dis ? ST_HOLD : ST_RUN;
                ST_RUN: begin
                    if (in_s.dis)      state_n = ST_HOLD;
                    else if (in_s.flt) state_n = ST_TRIP;
                end
                ST_HOLD:  if (!in_s.dis) state_n = ST_RUN;
                ST_TRIP:  if (tog) state_n = ST_RETRY;
                ST_RETRY: begin
                    if (in_s.dis)      state_n = ST_HOLD;
                    else if (in_s.flt) state_n = ST_TRIP;
                    else if (tmr_done) state_n = ST_RUN;
                end
                default:  state_n = ST_OFF;
            endcase
        end
    end

    // per-state timeout: the timer is reloaded on entry to a timed state
    always_comb begin
        tmr_load = (state_n != state_q) && timed_state(state_n);
        tmr_val  = timed_state(state_n) ? INIT_LOAD : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_OFF;
            stat_q  <= 2'b00;
        end else begin
            state_q <= state_n;
            stat_q  <= {state_q == ST_TRIP, in_s.dis};
        end
    end

    assign laser_on = laser_allowed(state_q);
    assign fault    = (state_q == ST_TRIP);
    assign stat     = stat_q;
endmodule

// File: rtl/ltx_fault_ctrl.sv
module ltx_fault_ctrl
    import ltx_pkg::*;
#(
    parameter int unsigned CLK_KHZ     = 100000,
    parameter int unsigned INIT_US     = 300000,
    parameter int unsigned DIS_MIN_US  = 10,
    parameter int          SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pwr_ok_i,
    input  logic       host_dis_i,
    input  logic       drv_fault_i,
    output logic       laser_on_o,
    output logic       fault_o,
    output logic [1:0] stat_o
);
    localparam int unsigned INIT_CYC = us_to_cycles(CLK_KHZ, INIT_US);
    localparam int unsigned DMIN_CYC = us_to_cycles(CLK_KHZ, DIS_MIN_US);
    localparam int          TW       = $clog2(INIT_CYC + 1);

    ltx_in_t       in_raw, in_s;
    logic          pwr_s, dis_s, flt_s;
    logic          tog;
    logic          tmr_done, tmr_load;
    logic [TW-1:0] tmr_val;

    assign in_raw = '{pwr: pwr_ok_i, dis: host_dis_i, flt: drv_fault_i};

    // disable resets high so the laser starts dark
    ltx_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (in_raw),
        .q   (in_s)
    );

    assign pwr_s = in_s.pwr;
    assign dis_s = in_s.dis;
    assign flt_s = in_s.flt;

    ltx_pulse_qual #(.MIN_CYC(int'(DMIN_CYC))) u_qual (
        .clk    (clk),
        .rst    (rst),
        .lvl    (dis_s),
        .accept (tog)
    );

    ltx_timer #(.CW(TW)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    ltx_fsm #(.INIT_CYC(INIT_CYC), .TW(TW)) u_fsm (
        .clk      (clk),
        .rst      (rst),
        .in_s     (in_s),
        .tog      (tog),
        .tmr_done (tmr_done),
        .tmr_load (tmr_load),
        .tmr_val  (tmr_val),
        .laser_on (laser_on_o),
        .fault    (fault_o),
        .stat     (stat_o)
    );
endmodule

// File: rtl/ltx_fault_ctrl_chk.sv
module ltx_fault_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       pwr_s,
    input logic       dis_s,
    input logic       tog,
    input logic       laser_on_o,
    input logic       fault_o,
    input logic [1:0] stat_o
);
    logic armed;

    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    assert_dis_dark_R3: assert property (@(posedge clk) disable iff (rst)
        (armed && dis_s) |=> !laser_on_o);

    assert_trip_dark_R5: assert property (@(posedge clk) disable iff (rst)
        (armed && $rose(fault_o)) |-> !laser_on_o);

    assert_short_kept_R6: assert property (@(posedge clk) disable iff (rst)
        (armed && fault_o && !tog && pwr_s) |=> fault_o);

    assert_clear_cause_R7: assert property (@(posedge clk) disable iff (rst)
        (armed && $fell(fault_o)) |-> ($past(tog) || !$past(pwr_s)));

    assert_stat_mirror_R8: assert property (@(posedge clk) disable iff (rst)
        armed |=> (stat_o[1] == $past(fault_o)));

    assert_pwr_loss_R9: assert property (@(posedge clk) disable iff (rst)
        (armed && !pwr_s) |=> (!laser_on_o && !fault_o));
endmodule

bind ltx_fault_ctrl ltx_fault_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .pwr_s      (pwr_s),
    .dis_s      (dis_s),
    .tog        (tog),
    .laser_on_o (laser_on_o),
    .fault_o    (fault_o),
    .stat_o     (stat_o)
);

// File: tb/tb_ltx_fault_ctrl.sv
module tb_ltx_fault_ctrl;
    localparam int INIT = 40;   // 1000 kHz * 40 us / 1000
    localparam int DMIN = 10;   // 1000 kHz * 10 us / 1000

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       pwr_ok_i = 1'b0;
    logic       host_dis_i = 1'b0;
    logic       drv_fault_i = 1'b0;
    logic       laser_on_o, fault_o;
    logic [1:0] stat_o;

    int cyc = 0;
    int checks = 0;
    int fails = 0;

    typedef struct {
        int       at;
        bit       is_stat;
        bit       en;
        bit       flt;
        bit [1:0] st;
        string    req;
    } exp_t;

    exp_t q[$];

    ltx_fault_ctrl #(
        .CLK_KHZ(1000), .INIT_US(40), .DIS_MIN_US(10), .SYNC_STAGES(2)
    ) dut (
        .clk(clk), .rst(rst), .pwr_ok_i(pwr_ok_i), .host_dis_i(host_dis_i),
        .drv_fault_i(drv_fault_i), .laser_on_o(laser_on_o),
        .fault_o(fault_o), .stat_o(stat_o)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic push(int d, bit en, bit flt, string r);
        exp_t e;
        e.at = cyc + d; e.is_stat = 1'b0; e.en = en; e.flt = flt; e.st = 2'b00; e.req = r;
        q.push_back(e);
    endtask

    task automatic push_st(int d, bit [1:0] st, string r);
        exp_t e;
        e.at = cyc + d; e.is_stat = 1'b1; e.en = 1'b0; e.flt = 1'b0; e.st = st; e.req = r;
        q.push_back(e);
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // monitor: compare queued expectations in their due cycle
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].at <= cyc) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (e.at < cyc) begin
                fails++;
                $display("FAIL %s: expectation for cycle %0d missed (now %0d)", e.req, e.at, cyc);
            end else if (e.is_stat) begin
                if (stat_o !== e.st) begin
                    fails++;
                    $display("FAIL %s cyc %0d: stat=%b expected %b", e.req, cyc, stat_o, e.st);
                end
            end else if (laser_on_o !== e.en || fault_o !== e.flt) begin
                fails++;
                $display("FAIL %s cyc %0d: laser_on=%b fault=%b expected %b/%b",
                         e.req, cyc, laser_on_o, fault_o, e.en, e.flt);
            end
        end
    end

    // driver
    initial begin
        tick(3);
        push(1, 0, 0, "R1");
        rst = 1'b0;
        push(2, 0, 0, "R1");
        tick(3);

        // R2 power-up initialization
        pwr_ok_i = 1'b1;
        push(3, 0, 0, "R2");
        push(2 + INIT, 0, 0, "R2");
        push(3 + INIT, 1, 0, "R2");
        tick(INIT + 6);

        // R3 disable, R8 status disable bit
        host_dis_i = 1'b1;
        push(2, 1, 0, "R3");
        push(3, 0, 0, "R3");
        push_st(3, 2'b01, "R8");
        tick(5);

        // R4 enable again
        host_dis_i = 1'b0;
        push(2, 0, 0, "R4");
        push(3, 1, 0, "R4");
        push_st(3, 2'b00, "R8");
        tick(5);

        // R5 fault latch
        drv_fault_i = 1'b1;
        push(2, 1, 0, "R5");
        push(3, 0, 1, "R5");
        push_st(4, 2'b10, "R8");
        tick(5);
        drv_fault_i = 1'b0;
        push(10, 0, 1, "R5");
        tick(12);

        // R6 short pulse ignored while latched
        host_dis_i = 1'b1;
        tick(DMIN - 1);
        host_dis_i = 1'b0;
        push(3, 0, 1, "R6");
        push(15, 0, 1, "R6");
        tick(17);

        // R7 qualified toggle, transient fault
        host_dis_i = 1'b1;
        push(6, 0, 1, "R7");
        tick(DMIN);
        host_dis_i = 1'b0;
        push(2, 0, 1, "R7");
        push(3, 1, 0, "R7");
        push(5 + INIT, 1, 0, "R7");
        tick(INIT + 8);

        // R7 qualified toggle, persistent fault
        drv_fault_i = 1'b1;
        push(3, 0, 1, "R5");
        tick(5);
        host_dis_i = 1'b1;
        tick(DMIN + 2);
        host_dis_i = 1'b0;
        push(3, 1, 0, "R7");
        push(4, 0, 1, "R7");
        tick(8);

        // R9 power cycle clears the fault
        pwr_ok_i = 1'b0;
        drv_fault_i = 1'b0;
        push(2, 0, 1, "R9");
        push(3, 0, 0, "R9");
        tick(5);
        pwr_ok_i = 1'b1;
        push(2 + INIT, 0, 0, "R9");
        push(3 + INIT, 1, 0, "R9");
        tick(INIT + 6);

        // R10 short pulse still gates the laser while running
        host_dis_i = 1'b1;
        push(3, 0, 0, "R10");
        tick(3);
        host_dis_i = 1'b0;
        push(2, 0, 0, "R10");
        push(3, 1, 0, "R10");
        tick(6);

        if (q.size() != 0) begin
            fails += q.size();
            checks += q.size();
            $display("FAIL end: %0d expectations never compared, expected 0", q.size());
        end
        summary();
        $finish;
    end

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not finish, cycle=%0d expected < 200000", cyc);
        summary();
        $finish;
    end
endmodule